// File: doc/BRIEF.md
# Multi-Mode Shift Register Unit

An eight-bit storage register whose next value is picked each clock by a three-bit opcode. In one cycle it can keep its contents, take a new parallel word, or move the word by exactly one bit position. The one-position moves are toward the LSB or toward the MSB with a bit taken from a pin, a sign-preserving move toward the LSB, a zero-filling move toward the MSB, a rotation toward the LSB, and an arithmetic doubling.

For the arithmetic doubling, the unit also raises a one-cycle overflow flag when the doubled value is no longer a valid signed result. This happens when the sign bit would change. Each bit position is a four-way selector in front of a flip-flop. The four choices are keep, take the higher neighbour, take the lower neighbour, and take the parallel input. A small decoder turns the opcode into that selector code and into the two bits fed in at the register ends. The external reset is asynchronous and active low. It takes effect at once but is released through a two-stage synchronizer.

Top module: `mshift_unit`

## Requirements
- R1: While reset is active, `q_out` is 0 and `ovf_out` is 0.
- R2: Opcode 3'b000 (keep): `q_out` stays unchanged after the clock edge, whatever `par_in`, `ser_top_in` and `ser_bot_in` carry.
- R3: Opcode 3'b011 (parallel load): `q_out` equals the `par_in` sampled at the clock edge.
- R4: Opcode 3'b001: the register moves one place toward the LSB. Bit 7 takes `ser_top_in`.
- R5: Opcode 3'b010: the register moves one place toward the MSB. Bit 0 takes `ser_bot_in`.
- R6: Opcode 3'b100 (arithmetic right): the new value is {old bit 7, old bits 7..1}, so the sign bit is kept. For example, 8'h63 becomes 8'h31.
- R7: Opcode 3'b101 (logical left): the new value is {old bits 6..0, 0}. For example, 8'h31 becomes 8'h62.
- R8: Opcode 3'b110 (rotate right): the new value is {old bit 0, old bits 7..1}. For example, 8'h62 becomes 8'h31.
- R9: Opcode 3'b111 (arithmetic left): the new value is {old bits 6..0, 0}. For example, 8'h31 (49) becomes 8'h62 (98).
- R10: `ovf_out` is set in the cycle after an opcode 3'b111 exactly when old bit 7 differs from old bit 6. After any other opcode it is 0.
- R11: Opcodes 3'b100 to 3'b111 ignore both serial pins and `par_in`. Opcodes other than 3'b011 ignore `par_in`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_in | input | 3 | Operation code |
| par_in | input | 8 | Parallel load word |
| ser_top_in | input | 1 | Bit entering the MSB on opcode 3'b001 |
| ser_bot_in | input | 1 | Bit entering the LSB on opcode 3'b010 |
| q_out | output | 8 | Register contents |
| ovf_out | output | 1 | Arithmetic-left overflow flag |

## Verification
Assertions are checked on every cycle for the following:
- each opcode's next-state relation against the previous contents;
- keep-mode stability;
- the zero state during reset;
- the overflow flag's set and clear rules.

The bench's scenarios are needed for the rest. They show the worked chain 8'h63 → 8'h31 → 8'h62 → 8'h31 → 8'h62 and negative values under the arithmetic moves. They also check that serial pins and parallel data have no effect on the contents in modes that do not use them, and that the flag drops after a keep cycle.

// File: rtl/mshift_pkg.sv
package mshift_pkg;

  typedef enum logic [2:0] {
    OP_HOLD    = 3'b000,
    OP_SHR_SER = 3'b001,
    OP_SHL_SER = 3'b010,
    OP_LOAD    = 3'b011,
    OP_ASR     = 3'b100,
    OP_LSL     = 3'b101,
    OP_ROR     = 3'b110,
    OP_ASL     = 3'b111
  } mshift_op_e;

  typedef enum logic [1:0] {
    SEL_KEEP      = 2'b00,
    SEL_FROM_UP   = 2'b01,
    SEL_FROM_DOWN = 2'b10,
    SEL_PAR       = 2'b11
  } mshift_sel_e;

endpackage

// File: rtl/mshift_rstsync.sv
module mshift_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/mshift_opdec.sv
module mshift_opdec
  import mshift_pkg::*;
(
  input  logic [2:0]  op,
  input  logic        ser_top,
  input  logic        ser_bot,
  input  logic        cur_msb,
  input  logic        cur_lsb,
  output mshift_sel_e sel,
  output logic        fill_top,
  output logic        fill_bot,
  output logic        asl_act
);

  mshift_op_e op_e;
  assign op_e = mshift_op_e'(op);

  always_comb begin
    sel      = SEL_KEEP;
    fill_top = 1'b0;
    fill_bot = 1'b0;
    asl_act  = 1'b0;
    case (op_e)
      OP_HOLD:    sel = SEL_KEEP;
      OP_SHR_SER: begin sel = SEL_FROM_UP;   fill_top = ser_top; end
      OP_SHL_SER: begin sel = SEL_FROM_DOWN; fill_bot = ser_bot; end
      OP_LOAD:    sel = SEL_PAR;
      OP_ASR:     begin sel = SEL_FROM_UP;   fill_top = cur_msb; end
      OP_LSL:     sel = SEL_FROM_DOWN;
      OP_ROR:     begin sel = SEL_FROM_UP;   fill_top = cur_lsb; end
      OP_ASL:     begin sel = SEL_FROM_DOWN; asl_act  = 1'b1;    end
      default:    sel = SEL_KEEP;
    endcase
  end

endmodule

// File: rtl/mshift_bitcell.sv
module mshift_bitcell
  import mshift_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  mshift_sel_e sel,
  input  logic        from_up,
  input  logic        from_down,
  input  logic        par_bit,
  output logic        q_bit
);

  logic cell_en;
  logic cell_d;

  always_comb begin
    cell_en = (sel != SEL_KEEP);
    case (sel)
      SEL_FROM_UP:   cell_d = from_up;
      SEL_FROM_DOWN: cell_d = from_down;
      SEL_PAR:       cell_d = par_bit;
      default:       cell_d = q_bit;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       q_bit <= 1'b0;
    else if (cell_en) q_bit <= cell_d;
  end

endmodule

// File: rtl/mshift_ovf.sv
module mshift_ovf (
  input  logic clk,
  input  logic rst_n,
  input  logic asl_act,
  input  logic sign_old,
  input  logic sign_new,
  output logic flag
);

  logic flag_d;

  always_comb begin
    flag_d = asl_act & (sign_old ^ sign_new);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag <= 1'b0;
    else        flag <= flag_d;
  end

  // R10: flag follows the sign change on an arithmetic-left step
  a_r10_ovf_set: assert property (@(posedge clk) disable iff (!rst_n)
    (asl_act && (sign_old != sign_new)) |=> flag);
  a_r10_ovf_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !(asl_act && (sign_old != sign_new)) |=> !flag);

endmodule

// File: rtl/mshift_unit.sv
module mshift_unit
  import mshift_pkg::*;
#(
  parameter int W          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [2:0]   op_in,
  input  logic [W-1:0] par_in,
  input  logic         ser_top_in,
  input  logic         ser_bot_in,
  output logic [W-1:0] q_out,
  output logic         ovf_out
);

  localparam int MSB = W - 1;

  logic        rst_sync_n;
  mshift_sel_e sel;
  logic        fill_top;
  logic        fill_bot;
  logic        asl_act;
  logic [W-1:0] q;
  logic [W+1:0] ext;

  mshift_rstsync #(.STAGES(SYNC_STAGES)) u_rstsync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  mshift_opdec u_opdec (
    .op       (op_in),
    .ser_top  (ser_top_in),
    .ser_bot  (ser_bot_in),
    .cur_msb  (q[MSB]),
    .cur_lsb  (q[0]),
    .sel      (sel),
    .fill_top (fill_top),
    .fill_bot (fill_bot),
    .asl_act  (asl_act)
  );

  assign ext = {fill_top, q, fill_bot};

  for (genvar i = 0; i < W; i++) begin : g_bit
    mshift_bitcell u_cell (
      .clk       (clk),
      .rst_n     (rst_sync_n),
      .sel       (sel),
      .from_up   (ext[i+2]),
      .from_down (ext[i]),
      .par_bit   (par_in[i]),
      .q_bit     (q[i])
    );
  end

  mshift_ovf u_ovf (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .asl_act  (asl_act),
    .sign_old (q[MSB]),
    .sign_new (q[MSB-1]),
    .flag     (ovf_out)
  );

  assign q_out = q;

  // R1: cleared while reset holds
  always @(posedge clk) begin
    if (!rst_sync_n) begin
      a_r1_reset_zero: assert (q == '0 && !ovf_out);
    end
  end

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_in == OP_HOLD) |=> $stable(q));
  a_r3_load: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_in == OP_LOAD) |=> (q == $past(par_in)));
  a_r4_ser_right: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_in == OP_SHR_SER) |=> (q == {$past(ser_top_in), $past(q[MSB:1])}));
  a_r5_ser_left: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_in == OP_SHL_SER) |=> (q == {$past(q[MSB-1:0]), $past(ser_bot_in)}));
  a_r6_asr: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_in == OP_ASR) |=> (q == {$past(q[MSB]), $past(q[MSB:1])}));
  a_r7_lsl: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_in == OP_LSL) |=> (q == {$past(q[MSB-1:0]), 1'b0}));
  a_r8_ror: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_in == OP_ROR) |=> (q == {$past(q[0]), $past(q[MSB:1])}));
  a_r9_asl: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_in == OP_ASL) |=> (q == {$past(q[MSB-1:0]), 1'b0}));

endmodule

// File: tb/mshift_unit_bench.sv
module mshift_unit_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] op_in;
  logic [7:0] par_in;
  logic       ser_top_in;
  logic       ser_bot_in;
  logic [7:0] q_out;
  logic       ovf_out;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  always #2 clk = ~clk;

  mshift_unit u_mshift_unit (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_in      (op_in),
    .par_in     (par_in),
    .ser_top_in (ser_top_in),
    .ser_bot_in (ser_bot_in),
    .q_out      (q_out),
    .ovf_out    (ovf_out)
  );

  task automatic chk8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s q_out actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk1(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s ovf_out actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic step(input logic [2:0] o, input logic [7:0] d, input logic st, input logic sb);
    @(negedge clk);
    op_in = o; par_in = d; ser_top_in = st; ser_bot_in = sb;
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset;
    rst_n = 1'b0; op_in = 3'b011; par_in = 8'hFF; ser_top_in = 1'b1; ser_bot_in = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk8("R1 reset", q_out, 8'h00);
    chk1("R1 reset", ovf_out, 1'b0);
    @(negedge clk);
    op_in = 3'b000;
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    chk8("R1 after release", q_out, 8'h00);
  endtask

  task automatic t_load;
    step(3'b011, 8'hA5, 1'b0, 1'b0);
    chk8("R3 load A5", q_out, 8'hA5);
    chk1("R10 no flag on load", ovf_out, 1'b0);
    step(3'b011, 8'h3C, 1'b1, 1'b1);
    chk8("R3 load 3C", q_out, 8'h3C);
  endtask

  task automatic t_hold;
    step(3'b000, 8'hFF, 1'b1, 1'b1);
    chk8("R2 hold 1", q_out, 8'h3C);
    step(3'b000, 8'h00, 1'b0, 1'b1);
    chk8("R2 hold 2", q_out, 8'h3C);
    chk1("R10 no flag on hold", ovf_out, 1'b0);
  endtask

  task automatic t_serial_right;
    step(3'b001, 8'h00, 1'b1, 1'b0);
    chk8("R4 ser right in 1", q_out, 8'h9E);
    step(3'b001, 8'hFF, 1'b0, 1'b1);
    chk8("R4 ser right in 0", q_out, 8'h4F);
  endtask

  task automatic t_serial_left;
    step(3'b010, 8'h00, 1'b0, 1'b1);
    chk8("R5 ser left in 1", q_out, 8'h9F);
    step(3'b010, 8'hFF, 1'b1, 1'b0);
    chk8("R5 ser left in 0", q_out, 8'h3E);
  endtask

  task automatic t_chain;
    step(3'b011, 8'h63, 1'b0, 1'b0);
    step(3'b100, 8'h00, 1'b0, 1'b0);
    chk8("R6 asr 63", q_out, 8'h31);
    step(3'b101, 8'h00, 1'b0, 1'b0);
    chk8("R7 lsl 31", q_out, 8'h62);
    step(3'b110, 8'h00, 1'b0, 1'b0);
    chk8("R8 ror 62", q_out, 8'h31);
    step(3'b111, 8'h00, 1'b0, 1'b0);
    chk8("R9 asl 31", q_out, 8'h62);
    chk1("R10 asl 31 no overflow", ovf_out, 1'b0);
  endtask

  task automatic t_negative;
    step(3'b011, 8'h81, 1'b0, 1'b0);
    step(3'b100, 8'h00, 1'b0, 1'b0);
    chk8("R6 asr negative", q_out, 8'hC0);
    step(3'b011, 8'h01, 1'b0, 1'b0);
    step(3'b110, 8'h00, 1'b0, 1'b0);
    chk8("R8 ror lsb wraps", q_out, 8'h80);
  endtask

  task automatic t_overflow;
    step(3'b011, 8'h40, 1'b0, 1'b0);
    step(3'b111, 8'h00, 1'b0, 1'b0);
    chk8("R9 asl 40", q_out, 8'h80);
    chk1("R10 asl 40 overflow", ovf_out, 1'b1);
    step(3'b111, 8'h00, 1'b0, 1'b0);
    chk8("R9 asl 80", q_out, 8'h00);
    chk1("R10 asl 80 overflow", ovf_out, 1'b1);
    step(3'b000, 8'h00, 1'b0, 1'b0);
    chk1("R10 flag drops after hold", ovf_out, 1'b0);
    step(3'b011, 8'hC0, 1'b0, 1'b0);
    step(3'b111, 8'h00, 1'b0, 1'b0);
    chk8("R9 asl C0", q_out, 8'h80);
    chk1("R10 asl C0 no overflow", ovf_out, 1'b0);
  endtask

  task automatic t_ignored;
    step(3'b011, 8'h5A, 1'b0, 1'b0);
    step(3'b100, 8'hFF, 1'b1, 1'b1);
    chk8("R11 asr ignores pins", q_out, 8'h2D);
    step(3'b101, 8'hFF, 1'b1, 1'b1);
    chk8("R11 lsl ignores pins", q_out, 8'h5A);
    step(3'b110, 8'hFF, 1'b1, 1'b1);
    chk8("R11 ror ignores pins", q_out, 8'h2D);
    step(3'b101, 8'h00, 1'b1, 1'b1);
    chk8("R11 lsl before asl", q_out, 8'h5A);
    step(3'b111, 8'hFF, 1'b1, 1'b1);
    chk8("R11 asl ignores pins", q_out, 8'hB4);
    chk1("R10 asl 5A overflow", ovf_out, 1'b1);
    step(3'b001, 8'hFF, 1'b0, 1'b1);
    chk8("R11 ser right ignores par_in", q_out, 8'h5A);
  endtask

  initial begin
    t_reset();
    t_load();
    t_hold();
    t_serial_right();
    t_serial_left();
    t_chain();
    t_negative();
    t_overflow();
    t_ignored();
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule